// File: doc/BRIEF.md
# Two-Wire Pin Watcher to Transaction Bridge

This block sits between a pair of two-wire serial lines toggled by software (clock line and data line, sampled on the core clock) and a simple target back-end that works in whole bytes. It follows every pin-level transition. It spots start and stop conditions and shifts in the address byte and the write bytes. Each event becomes a single-cycle request towards the target: open a transfer, write a byte, fetch a byte, report that the master refused a byte, or close the transfer.

The block drives one open-drain style data bit of its own. The level the master sees is that bit ANDed with the master's own data level. Protocol work happens only on a rising clock line. A falling clock line always releases the data bit. When the target refuses an address or a byte, the transfer is closed at once, as if a stop had been seen. A registered one-cycle pulse marks every change of the resolved data level.

Top module: `i2cb_bridge`

## Requirements
- R1: A core-clock cycle in which neither line differs from its last recorded level produces no target strobe, no change of `sda_o` and no change pulse.
- R2: With the clock line high, a falling data line is a start: eight address bits are expected next and any captured address is forgotten, without a close request. A rising data line is a stop: the block goes idle. Both release the device bit to 1.
- R3: A data-line change while the clock line is low only records the new level, so `sda_o` follows it one cycle later while the device bit is released.
- R4: A falling clock line releases the device bit to 1 and changes no protocol state. `sda_o` equals the master's data level one cycle after it.
- R5: In the eight master bit cycles, data is shifted in MSB first on each clock rise. On the ninth rise after a start, `tgt_begin_o` pulses with `tgt_addr_o` = byte[7:1] and `tgt_rd_o` = byte[0] (1 = read). Target strobes only ever occur in a cycle where the clock line rises.
- R6: After an address has been accepted for writing, each further byte is handed over by `tgt_wr_o` with `tgt_wdata_o` on the ninth rise. Each accepted address or byte is acknowledged by driving the device bit to 0 until the next clock fall.
- R7: If `tgt_rej_i` is high while a begin or write strobe is issued, `tgt_end_o` pulses in the same cycle, the block goes idle and the device bit stays released.
- R8: In read mode, `tgt_rdreq_o` pulses on the first of eight clock rises and `tgt_rdata_i` is sampled then. Its bits are driven MSB first, one per rise.
- R9: On the ninth rise of a read byte, a master data level of 1 pulses `tgt_mnack_o` and parks the block with the device bit released until the next start or stop. A level of 0 starts another read byte.
- R10: `sda_o` is the device bit ANDed with the recorded master data level. When idle or parked after a refusal, `sda_o` simply follows the master.
- R11: After reset both recorded levels and the device bit are 1. A stop pulses `tgt_end_o` only when an address is held.
- R12: `sda_chg_o` is high for exactly the cycles in which `sda_o` differs from its value one cycle earlier.
- R13: When both lines change in the same cycle, only the clock transition is acted on. The data-line change is recorded and never taken as a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Master clock line level |
| sda_i | input | 1 | Master data line level |
| sda_o | output | 1 | Resolved data level seen by the master |
| sda_chg_o | output | 1 | One-cycle pulse on a change of `sda_o` |
| tgt_begin_o | output | 1 | Open-transfer strobe |
| tgt_addr_o | output | 7 | Target address, valid with `tgt_begin_o` |
| tgt_rd_o | output | 1 | Direction, 1 = read, valid with `tgt_begin_o` |
| tgt_wr_o | output | 1 | Write-byte strobe |
| tgt_wdata_o | output | 8 | Write byte, valid with `tgt_wr_o` |
| tgt_rdreq_o | output | 1 | Read-byte fetch strobe |
| tgt_rdata_i | input | 8 | Read byte, sampled with `tgt_rdreq_o` |
| tgt_rej_i | input | 1 | Target refuses the current begin or write |
| tgt_mnack_o | output | 1 | Master refused the last read byte |
| tgt_end_o | output | 1 | Close-transfer strobe |

## Verification
The checker watches, on every cycle, that quiet cycles stay quiet, that strobes occur only on a clock rise, and that a clock fall releases the line. It also checks that a close request only ever follows a held or just-opened address, and that the change pulse matches the observed level history. Bit ordering, address and direction decoding, acknowledge levels, the read fetch timing, master refusal, target refusal and the simultaneous-edge priority can only be shown by the bench. Its transactions compare every bit and strobe against values worked out from the requirements.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBIT,
    ST_WACK,
    ST_RBIT,
    ST_MACK,
    ST_PARK
  } st_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } ev_t;
endpackage

// File: rtl/i2cb_lines.sv
module i2cb_lines
  import i2cb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic last_scl_o,
  output logic last_sda_o,
  output ev_t  ev_o
);
  logic scl_q, sda_q;
  logic scl_chg, sda_chg;

  assign scl_chg = scl_i ^ scl_q;
  assign sda_chg = sda_i ^ sda_q;

  // clock edge wins over a data change in the same cycle
  always_comb begin
    ev_o.scl_rise = scl_chg & scl_i;
    ev_o.scl_fall = scl_chg & ~scl_i;
    ev_o.start    = ~scl_chg & sda_chg & scl_q & ~sda_i;
    ev_o.stop     = ~scl_chg & sda_chg & scl_q & sda_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign last_scl_o = scl_q;
  assign last_sda_o = sda_q;
endmodule

// File: rtl/i2cb_fsm.sv
module i2cb_fsm
  import i2cb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ev_t               ev_i,
  input  logic              sda_last_i,
  input  logic              rej_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              begin_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rdreq_o,
  output logic              mnack_o,
  output logic              end_o,
  output logic              dev_ld_o,
  output logic              dev_val_o,
  output logic              avld_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  st_e              st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DATA_W-1:0] buf_q, buf_n, rword;
  logic             avld_q, avld_n;
  logic             rd_q, rd_n;
  logic             go_rd;

  assign rword = (cnt_q == '0) ? rdata_i : buf_q;
  assign go_rd = avld_q ? rd_q : buf_q[0];

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    buf_n     = buf_q;
    avld_n    = avld_q;
    rd_n      = rd_q;
    begin_o   = 1'b0;
    wr_o      = 1'b0;
    rdreq_o   = 1'b0;
    mnack_o   = 1'b0;
    end_o     = 1'b0;
    dev_ld_o  = 1'b0;
    dev_val_o = 1'b1;
    if (ev_i.start) begin
      st_n     = ST_WBIT;
      cnt_n    = '0;
      avld_n   = 1'b0;
      dev_ld_o = 1'b1;
    end else if (ev_i.stop) begin
      end_o    = avld_q;
      st_n     = ST_IDLE;
      avld_n   = 1'b0;
      dev_ld_o = 1'b1;
    end else if (ev_i.scl_fall) begin
      dev_ld_o = 1'b1;
    end else if (ev_i.scl_rise) begin
      dev_ld_o = 1'b1;
      case (st_q)
        ST_WBIT: begin
          buf_n = {buf_q[DATA_W-2:0], sda_last_i};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            st_n  = ST_WACK;
            cnt_n = '0;
          end
        end
        ST_WACK: begin
          if (!avld_q) begin
            begin_o = 1'b1;
            avld_n  = 1'b1;
            rd_n    = buf_q[0];
          end else begin
            wr_o = 1'b1;
          end
          if (rej_i) begin
            end_o  = 1'b1;
            avld_n = 1'b0;
            st_n   = ST_IDLE;
          end else begin
            dev_val_o = 1'b0;
            st_n      = go_rd ? ST_RBIT : ST_WBIT;
          end
        end
        ST_RBIT: begin
          rdreq_o   = (cnt_q == '0);
          dev_val_o = rword[DATA_W-1];
          buf_n     = {rword[DATA_W-2:0], 1'b0};
          cnt_n     = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            st_n  = ST_MACK;
            cnt_n = '0;
          end
        end
        ST_MACK: begin
          if (sda_last_i) begin
            mnack_o = 1'b1;
            st_n    = ST_PARK;
          end else begin
            st_n = ST_RBIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      buf_q  <= '0;
      avld_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      buf_q  <= buf_n;
      avld_q <= avld_n;
      rd_q   <= rd_n;
    end
  end

  assign addr_o  = buf_q[DATA_W-1:1];
  assign rd_o    = buf_q[0];
  assign wdata_o = buf_q;
  assign avld_o  = avld_q;
endmodule

// File: rtl/i2cb_drive.sv
module i2cb_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_ld_i,
  input  logic dev_val_i,
  input  logic sda_now_i,
  input  logic sda_last_i,
  output logic sda_o,
  output logic chg_o
);
  logic dev_q, dev_n;
  logic res_q, res_n;
  logic chg_q;

  assign dev_n = dev_ld_i ? dev_val_i : dev_q;
  assign res_n = dev_n & sda_now_i;
  assign res_q = dev_q & sda_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= 1'b1;
      chg_q <= 1'b0;
    end else begin
      dev_q <= dev_n;
      chg_q <= res_n ^ res_q;
    end
  end

  assign sda_o = res_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/i2cb_bridge.sv
module i2cb_bridge
  import i2cb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_chg_o,
  output logic              tgt_begin_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              tgt_rd_o,
  output logic              tgt_wr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  output logic              tgt_rdreq_o,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  input  logic              tgt_rej_i,
  output logic              tgt_mnack_o,
  output logic              tgt_end_o
);
  ev_t  ev;
  logic last_scl, last_sda;
  logic dev_ld, dev_val, addr_vld;

  i2cb_lines u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .last_scl_o (last_scl),
    .last_sda_o (last_sda),
    .ev_o       (ev)
  );

  i2cb_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .sda_last_i (last_sda),
    .rej_i      (tgt_rej_i),
    .rdata_i    (tgt_rdata_i),
    .begin_o    (tgt_begin_o),
    .addr_o     (tgt_addr_o),
    .rd_o       (tgt_rd_o),
    .wr_o       (tgt_wr_o),
    .wdata_o    (tgt_wdata_o),
    .rdreq_o    (tgt_rdreq_o),
    .mnack_o    (tgt_mnack_o),
    .end_o      (tgt_end_o),
    .dev_ld_o   (dev_ld),
    .dev_val_o  (dev_val),
    .avld_o     (addr_vld)
  );

  i2cb_drive u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_ld_i   (dev_ld),
    .dev_val_i  (dev_val),
    .sda_now_i  (sda_i),
    .sda_last_i (last_sda),
    .sda_o      (sda_o),
    .chg_o      (sda_chg_o)
  );
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic last_scl,
  input logic last_sda,
  input logic addr_vld,
  input logic sda_o,
  input logic sda_chg_o,
  input logic tgt_begin_o,
  input logic tgt_wr_o,
  input logic tgt_rdreq_o,
  input logic tgt_mnack_o,
  input logic tgt_end_o
);
  logic quiet, any_stb;
  assign quiet   = (scl_i == last_scl) && (sda_i == last_sda);
  assign any_stb = tgt_begin_o | tgt_wr_o | tgt_rdreq_o | tgt_mnack_o;

  AST_QUIET_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> !(any_stb || tgt_end_o)); // R1
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> $stable(sda_o)); // R1
  AST_STROBE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> (scl_i && !last_scl)); // R5
  AST_FALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_scl && !scl_i && (sda_i == last_sda)) |=> (sda_o == last_sda)); // R4
  AST_END_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_end_o |-> (addr_vld || tgt_begin_o)); // R11
  AST_CHG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |-> (sda_o != $past(sda_o))); // R12
endmodule

bind i2cb_bridge i2cb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .last_scl    (last_scl),
  .last_sda    (last_sda),
  .addr_vld    (addr_vld),
  .sda_o       (sda_o),
  .sda_chg_o   (sda_chg_o),
  .tgt_begin_o (tgt_begin_o),
  .tgt_wr_o    (tgt_wr_o),
  .tgt_rdreq_o (tgt_rdreq_o),
  .tgt_mnack_o (tgt_mnack_o),
  .tgt_end_o   (tgt_end_o)
);

// File: tb/sim_i2cb_bridge.sv
module sim_i2cb_bridge;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, scl, sda, rej;
  logic [7:0] rdat;
  logic       sda_o, sda_chg, t_begin, t_rd, t_wr, t_rdreq, t_mnack, t_end;
  logic [6:0] t_addr;
  logic [7:0] t_wdata;

  i2cb_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_o(sda_o), .sda_chg_o(sda_chg),
    .tgt_begin_o(t_begin), .tgt_addr_o(t_addr), .tgt_rd_o(t_rd),
    .tgt_wr_o(t_wr), .tgt_wdata_o(t_wdata), .tgt_rdreq_o(t_rdreq),
    .tgt_rdata_i(rdat), .tgt_rej_i(rej), .tgt_mnack_o(t_mnack), .tgt_end_o(t_end)
  );

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  logic c_begin, c_rd, c_wr, c_rdreq, c_mnack, c_end;
  logic [6:0] c_addr;
  logic [7:0] c_wdata;
  logic o_sda, o_chg, prev_o;
  logic m_scl, m_sda;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit no_stb();
    return !(c_begin || c_wr || c_rdreq || c_mnack || c_end);
  endfunction

  task automatic drv(input logic c, input logic d);
    @(negedge clk);
    scl = c; sda = d; m_scl = c; m_sda = d;
    #1;
    c_begin = t_begin; c_addr = t_addr; c_rd = t_rd; c_wr = t_wr;
    c_wdata = t_wdata; c_rdreq = t_rdreq; c_mnack = t_mnack; c_end = t_end;
    @(posedge clk);
    #1;
    o_sda = sda_o; o_chg = sda_chg;
    chk(o_chg == (o_sda != prev_o), "R12", int'(o_chg), int'(o_sda != prev_o));
    prev_o = o_sda;
  endtask

  task automatic rise_bit(input logic d);
    if (m_scl) drv(1'b0, m_sda);
    if (d != m_sda) drv(1'b0, d);
    drv(1'b1, d);
  endtask

  task automatic do_start();
    if (m_scl) drv(1'b0, m_sda);
    drv(1'b0, 1'b1);
    drv(1'b1, 1'b1);
    drv(1'b1, 1'b0);
    chk(no_stb() && o_sda == 1'b0, "R2", int'(o_sda), 0);
  endtask

  task automatic do_stop(input bit exp_end);
    if (m_scl) drv(1'b0, m_sda);
    drv(1'b0, 1'b0);
    drv(1'b1, 1'b0);
    drv(1'b1, 1'b1);
    chk(c_end == exp_end, "R11", int'(c_end), int'(exp_end));
    chk(o_sda == 1'b1, "R2", int'(o_sda), 1);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      rise_bit(b[i]);
      chk(o_sda == b[i], "R3", int'(o_sda), int'(b[i]));
      chk(no_stb(), "R5", 1, 0);
    end
  endtask

  // rej_at: -1 none, 0 at address, k refuses write byte k
  task automatic txn(input logic [6:0] a, input bit rd, input int nb, input int rej_at, input bit simul);
    logic [7:0] ab, data, exp_b;
    ab = {a, rd};
    do_start();
    if (simul) begin
      drv(1'b0, 1'b1);  // both lines move: clock fall only
      chk(no_stb() && o_sda == 1'b1, "R13", int'(o_sda), 1);
      drv(1'b1, 1'b1);
      for (int i = 6; i >= 0; i--) begin
        rise_bit(ab[i]);
        chk(o_sda == ab[i], "R3", int'(o_sda), int'(ab[i]));
      end
    end else begin
      send_bits(ab);
    end
    rej = (rej_at == 0);
    rise_bit(1'b1);
    rej = 1'b0;
    chk(c_begin && c_addr == a && c_rd == rd, "R5", int'({c_begin, c_addr, c_rd}), int'({1'b1, a, rd}));
    if (rej_at == 0) begin
      chk(c_end && o_sda == 1'b1, "R7", int'({c_end, o_sda}), 3);
      rise_bit(1'b0);
      chk(no_stb() && o_sda == 1'b0, "R10", int'(o_sda), 0);
      do_stop(1'b0);
      return;
    end
    chk(!c_end && o_sda == 1'b0, "R6", int'(o_sda), 0);
    drv(1'b0, 1'b1);
    chk(o_sda == 1'b1, "R4", int'(o_sda), 1);
    if (!rd) begin
      for (int k = 1; k <= nb; k++) begin
        data = 8'($urandom);
        send_bits(data);
        rej = (rej_at == k);
        rise_bit(1'b1);
        rej = 1'b0;
        chk(c_wr && c_wdata == data, "R6", int'(c_wdata), int'(data));
        if (rej_at == k) begin
          chk(c_end && o_sda == 1'b1, "R7", int'({c_end, o_sda}), 3);
          do_stop(1'b0);
          return;
        end
        chk(o_sda == 1'b0, "R6", int'(o_sda), 0);
      end
      do_stop(1'b1);
    end else begin
      for (int k = 1; k <= nb; k++) begin
        exp_b = 8'($urandom);
        rdat = exp_b;
        for (int j = 0; j < 8; j++) begin
          rise_bit(1'b1);
          if (j == 0) rdat = ~exp_b;  // sampled only with the fetch strobe
          chk(c_rdreq == (j == 0), "R8", int'(c_rdreq), int'(j == 0));
          chk(o_sda == exp_b[7-j], "R8", int'(o_sda), int'(exp_b[7-j]));
          if (j == 3) begin
            drv(m_scl, m_sda);
            chk(no_stb() && !o_chg && o_sda == exp_b[4], "R1", int'(o_sda), int'(exp_b[4]));
          end
        end
        rise_bit(k == nb);
        chk(c_mnack == (k == nb), "R9", int'(c_mnack), int'(k == nb));
        chk(o_sda == (k == nb), "R9", int'(o_sda), int'(k == nb));
      end
      for (int j = 0; j < 2; j++) begin
        rise_bit(1'b1);
        chk(no_stb() && o_sda == 1'b1, "R9", int'(o_sda), 1);
      end
      do_stop(1'b1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; rej = 1'b0; rdat = '0;
    m_scl = 1'b1; m_sda = 1'b1; prev_o = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(sda_o == 1'b1 && sda_chg == 1'b0, "R11", int'({sda_o, sda_chg}), 2);
    chk(!(t_begin || t_wr || t_rdreq || t_mnack || t_end), "R11", 1, 0);
    // stop with no address held
    do_stop(1'b0);
    // idle: line follows master
    rise_bit(1'b0);
    chk(no_stb() && o_sda == 1'b0, "R10", int'(o_sda), 0);
    rise_bit(1'b1);
    chk(no_stb() && o_sda == 1'b1, "R10", int'(o_sda), 1);
    // directed corners
    txn(7'h51, 1'b0, 2, -1, 1'b1);
    txn(7'h2a, 1'b1, 2, -1, 1'b0);
    txn(7'h7f, 1'b0, 1, 0, 1'b0);
    txn(7'h00, 1'b0, 3, 2, 1'b0);
    txn(7'h33, 1'b1, 1, 0, 1'b0);
    // constrained random
    for (int t = 0; t < 16; t++) begin
      logic [6:0] a;
      bit rd;
      int nb, r, ra;
      a  = 7'($urandom);
      rd = 1'($urandom);
      nb = 1 + int'($urandom % 3);
      r  = int'($urandom % 6);
      ra = (r == 0) ? 0 : ((!rd && r == 1) ? 1 + int'($urandom % nb) : -1);
      txn(a, rd, nb, ra, 1'b0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule